// File: doc/BRIEF.md
# DDR Clock PLL Reprogramming Sequencer

This block retunes the PLL that feeds a DDR memory clock to one of four fixed operating points. A request carries a frequency code and a start strobe. The sequencer then takes these steps in order:

1. It moves the clock consumer onto the slow bypass source.
2. It holds the PLL in reset.
3. It loads the reference, output and feedback dividers. Each divider is stored as its value minus one.
4. It waits a fixed settling time of ten microseconds.
5. It releases reset.
6. It polls the lock flag.
7. On lock it returns the consumer to the PLL output, which is normal mode.

The block can also derive a loop-bandwidth setting from the feedback divider and load it with the dividers.

A code outside the four supported points is refused. The block pulses an error and changes no output. If lock never arrives within a bounded window, the block also pulses an error. In that case the clock stays on the slow source and the PLL is out of reset. A completed retune ends with a one-cycle done pulse.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, mode_slow, pll_rst, all divider fields, bwadj_m1, done and error are all 0.
- R2: The supported codes load the following fields, each value minus one:

  | Code | Frequency | fb_m1 | ref_m1 | od_m1 |
  |------|-----------|-------|--------|-------|
  | 0 | 300 MHz | 24 | 1 | 0 |
  | 1 | 533 MHz | 399 | 8 | 1 |
  | 2 | 666 MHz | 499 | 8 | 1 |
  | 3 | 800 MHz | 99 | 2 | 0 |

- R3: The steps follow a fixed cycle order. mode_slow rises one cycle after start is sampled. pll_rst rises one cycle after that. The dividers change one further cycle later. pll_rst is never high while mode_slow is low.
- R4: pll_rst falls exactly SETTLE_CYC = CLK_HZ/100000 cycles after the dividers load. This is 500 cycles at 50 MHz, equal to 10 µs.
- R5: When bwadj_en is 1 at start, bwadj_m1 is loaded with (feedback/2)-1 together with the dividers. When it is 0, bwadj_m1 keeps its previous value.
- R6: A start with a code of 4 to 7 produces a one-cycle error pulse on the next cycle. mode_slow, pll_rst and every divider field stay unchanged.
- R7: Once pll_lock is seen after release, mode_slow returns to 0 and done pulses for one cycle.
- R8: If pll_lock stays low for LOCK_TIMEOUT cycles after release, error pulses, mode_slow stays 1 and pll_rst stays 0.
- R9: A start asserted while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a retune (sampled when idle) |
| freq_code | input | 3 | Requested operating point, 0..3 valid |
| bwadj_en | input | 1 | Load the bandwidth field during this retune |
| pll_lock | input | 1 | Lock flag from the PLL |
| mode_slow | output | 1 | 1 = consumer on slow bypass clock, 0 = normal |
| pll_rst | output | 1 | PLL reset |
| ref_div_m1 | output | 6 | Reference divider minus one |
| out_div_m1 | output | 4 | Output divider minus one |
| fb_div_m1 | output | 13 | Feedback divider minus one |
| bwadj_m1 | output | 12 | Bandwidth-adjust field |
| done | output | 1 | One-cycle pulse on successful retune |
| error | output | 1 | One-cycle pulse on refused code or lock timeout |

## Verification
The bench targets the following corner cases and the failure each would expose:

- **Step order.** A design that loaded the dividers before reset would show new divider values in the cycle pll_rst rises.
- **Settle length.** A counter off by one would release reset at cycle 502 or 504 instead of 503.
- **Refused codes.** A design that did not refuse them would enter slow mode or alter fields. A design whose error was not a pulse would show the error high a cycle late.
- **Lock timeout.** A design that returned to normal mode on timeout would show mode_slow low at the error.
- **Bandwidth enable off.** A design that ignored the enable would overwrite the bandwidth field.
- **Start while busy.** A design that honoured a mid-sequence start would end with the wrong dividers or a shifted release.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int CODE_W = 3;
    localparam int REF_W  = 6;
    localparam int OD_W   = 4;
    localparam int FB_W   = 13;
    localparam int BW_W   = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_LOAD,
        ST_SETTLE,
        ST_LOCK
    } seq_st_e;

    typedef struct packed {
        logic [REF_W-1:0] ref_div;
        logic [OD_W-1:0]  out_div;
        logic [FB_W-1:0]  fb_div;
    } div_set_t;
endpackage

// File: rtl/pll_div_table.sv
module pll_div_table
    import pll_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output div_set_t          divs
);
    always_comb begin
        valid = 1'b1;
        divs  = '0;
        case (code)
            CODE_W'(0): divs = '{ref_div: REF_W'(2), out_div: OD_W'(1), fb_div: FB_W'(25)};
            CODE_W'(1): divs = '{ref_div: REF_W'(9), out_div: OD_W'(2), fb_div: FB_W'(400)};
            CODE_W'(2): divs = '{ref_div: REF_W'(9), out_div: OD_W'(2), fb_div: FB_W'(500)};
            CODE_W'(3): divs = '{ref_div: REF_W'(3), out_div: OD_W'(1), fb_div: FB_W'(100)};
            default:    valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pll_cycle_timer.sv
module pll_cycle_timer #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + CNT_W'(1) : '0;
        hit   = run && (cnt_q == CNT_W'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int SETTLE_US    = 10,
    parameter int LOCK_TIMEOUT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] freq_code,
    input  logic              bwadj_en,
    input  logic              pll_lock,
    output logic              mode_slow,
    output logic              pll_rst,
    output logic [REF_W-1:0]  ref_div_m1,
    output logic [OD_W-1:0]   out_div_m1,
    output logic [FB_W-1:0]   fb_div_m1,
    output logic [BW_W-1:0]   bwadj_m1,
    output logic              done,
    output logic              error
);
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    typedef struct packed {
        seq_st_e           st;
        logic [CODE_W-1:0] code;
        logic              bwen;
        logic              slow;
        logic              rst;
        logic [REF_W-1:0]  ref_m1;
        logic [OD_W-1:0]   od_m1;
        logic [FB_W-1:0]   fb_m1;
        logic [BW_W-1:0]   bw_m1;
        logic              done;
        logic              err;
    } seq_t;

    seq_t     s_d, s_q;
    logic     req_valid, cur_valid;
    div_set_t req_divs, cur_divs;
    logic     settle_hit, timeout_hit;
    logic [FB_W-1:0] fb_half;

    pll_div_table u_req_tbl (.code(freq_code), .valid(req_valid), .divs(req_divs));
    pll_div_table u_cur_tbl (.code(s_q.code),  .valid(cur_valid), .divs(cur_divs));

    pll_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(s_q.st == ST_SETTLE), .hit(settle_hit)
    );

    pll_cycle_timer #(.LIMIT(LOCK_TIMEOUT)) u_lock_to (
        .clk(clk), .rst_n(rst_n), .run((s_q.st == ST_LOCK) && !pll_lock), .hit(timeout_hit)
    );

    assign fb_half = cur_divs.fb_div >> 1;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (req_valid) begin
                        s_d.code = freq_code;
                        s_d.bwen = bwadj_en;
                        s_d.slow = 1'b1;
                        s_d.st   = ST_RST;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_RST: begin
                s_d.rst = 1'b1;
                s_d.st  = ST_LOAD;
            end
            ST_LOAD: begin
                if (cur_valid) begin
                    s_d.ref_m1 = cur_divs.ref_div - REF_W'(1);
                    s_d.od_m1  = cur_divs.out_div - OD_W'(1);
                    s_d.fb_m1  = cur_divs.fb_div - FB_W'(1);
                    if (s_q.bwen) s_d.bw_m1 = BW_W'(fb_half - FB_W'(1));
                end
                s_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_hit) begin
                    s_d.rst = 1'b0;
                    s_d.st  = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (pll_lock) begin
                    s_d.slow = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end else if (timeout_hit) begin
                    s_d.err = 1'b1;
                    s_d.st  = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mode_slow  = s_q.slow;
    assign pll_rst    = s_q.rst;
    assign ref_div_m1 = s_q.ref_m1;
    assign out_div_m1 = s_q.od_m1;
    assign fb_div_m1  = s_q.fb_m1;
    assign bwadj_m1   = s_q.bw_m1;
    assign done       = s_q.done;
    assign error      = s_q.err;

    // Independent count of cycles spent in PLL reset, for the settle check.
    int unsigned rst_hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rst_hi_cnt <= 0;
        else if (pll_rst) rst_hi_cnt <= rst_hi_cnt + 1;
        else              rst_hi_cnt <= 0;
    end

    assert_rst_in_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> mode_slow);

    assert_settle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst) |-> rst_hi_cnt == SETTLE_CYC + 1);

    assert_bw_only_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bwadj_m1) |-> ($past(s_q.st) == ST_LOAD) && $past(s_q.bwen));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && start && freq_code > CODE_W'(3)) |=>
            error && $stable(mode_slow) && $stable(pll_rst) && $stable(fb_div_m1)
            && $stable(ref_div_m1) && $stable(out_div_m1));

    assert_done_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mode_slow && !pll_rst && !error);

    assert_err_out_of_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !pll_rst && !done);
endmodule

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
    localparam int SETTLE = 500;
    localparam int TMO    = 1000;
    localparam int LOCK_LAT = 20;

    // vector table: code, fb_m1, ref_m1, od_m1, bwadj_m1
    localparam int V_CODE[4] = '{0, 1, 2, 3};
    localparam int V_FB[4]   = '{24, 399, 499, 99};
    localparam int V_REF[4]  = '{1, 8, 8, 2};
    localparam int V_OD[4]   = '{0, 1, 1, 0};
    localparam int V_BW[4]   = '{11, 199, 249, 49};

    logic clk = 0, rst_n = 0, start = 0, bwadj_en = 0, pll_lock = 0;
    logic [2:0] freq_code = 0;
    logic mode_slow, pll_rst, done, error;
    logic [5:0] ref_div_m1;
    logic [3:0] out_div_m1;
    logic [12:0] fb_div_m1;
    logic [11:0] bwadj_m1;

    int checks = 0, failures = 0, cycles = 0;
    bit force_nolock = 0, poke_busy = 0;
    int lk_cnt = 0;
    int t_slow, t_rst, t_rel, t_done, t_err, fb_t2, fb_t3, err_next;

    always #10 clk = ~clk;

    pll_reprog_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_code(freq_code),
        .bwadj_en(bwadj_en), .pll_lock(pll_lock), .mode_slow(mode_slow),
        .pll_rst(pll_rst), .ref_div_m1(ref_div_m1), .out_div_m1(out_div_m1),
        .fb_div_m1(fb_div_m1), .bwadj_m1(bwadj_m1), .done(done), .error(error)
    );

    // PLL model: lock LOCK_LAT cycles after reset release
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (pll_rst || force_nolock) begin
            lk_cnt   <= 0;
            pll_lock <= 0;
        end else if (lk_cnt < LOCK_LAT) begin
            lk_cnt <= lk_cnt + 1;
        end else begin
            pll_lock <= 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input int code, input bit bwen);
        t_slow = -1; t_rst = -1; t_rel = -1; t_done = -1; t_err = -1;
        fb_t2 = -1; fb_t3 = -1; err_next = -1;
        @(negedge clk);
        freq_code = code[2:0]; bwadj_en = bwen; start = 1;
        for (int t = 1; t <= 3000; t++) begin
            @(negedge clk);
            if (t == 1) start = 0;
            if (poke_busy && t == 100) begin start = 1; freq_code = 3'd0; end
            if (poke_busy && t == 101) start = 0;
            if (t == 2) fb_t2 = int'(fb_div_m1);
            if (t == 3) fb_t3 = int'(fb_div_m1);
            if (t_slow < 0 && mode_slow) t_slow = t;
            if (t_rst < 0 && pll_rst) t_rst = t;
            if (t_rst >= 0 && t_rel < 0 && !pll_rst) t_rel = t;
            if (t_err >= 0) begin err_next = int'(error); break; end
            if (error) t_err = t;
            if (done) begin t_done = t; break; end
        end
    endtask

    initial begin
        int prev_fb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mode_slow == 0 && pll_rst == 0, "R1", "slow/rst", {mode_slow, pll_rst}, 0);
        chk(fb_div_m1 == 0 && ref_div_m1 == 0 && out_div_m1 == 0 && bwadj_m1 == 0,
            "R1", "fields", int'(fb_div_m1), 0);
        chk(done == 0 && error == 0, "R1", "done/err", {done, error}, 0);
        rst_n = 1;

        prev_fb = 0;
        for (int i = 0; i < 4; i++) begin
            run_seq(V_CODE[i], 1'b1);
            chk(t_slow == 1, "R3", "slow cycle", t_slow, 1);
            chk(t_rst == 2, "R3", "reset cycle", t_rst, 2);
            chk(fb_t2 == prev_fb, "R3", "fb before load", fb_t2, prev_fb);
            chk(fb_t3 == V_FB[i], "R3", "fb at load", fb_t3, V_FB[i]);
            chk(t_rel == 3 + SETTLE, "R4", "release cycle", t_rel, 3 + SETTLE);
            chk(t_done > t_rel && t_err < 0, "R7", "done after release", t_done, t_rel + LOCK_LAT);
            chk(mode_slow == 0, "R7", "normal mode at done", int'(mode_slow), 0);
            chk(int'(fb_div_m1) == V_FB[i], "R2", "fb_m1", int'(fb_div_m1), V_FB[i]);
            chk(int'(ref_div_m1) == V_REF[i], "R2", "ref_m1", int'(ref_div_m1), V_REF[i]);
            chk(int'(out_div_m1) == V_OD[i], "R2", "od_m1", int'(out_div_m1), V_OD[i]);
            chk(int'(bwadj_m1) == V_BW[i], "R5", "bwadj_m1", int'(bwadj_m1), V_BW[i]);
            @(negedge clk);
            chk(done == 0, "R7", "done one cycle", int'(done), 0);
            prev_fb = V_FB[i];
        end

        // R5 bandwidth field untouched when disabled
        run_seq(1, 1'b0);
        chk(int'(fb_div_m1) == 399, "R5", "fb with bw off", int'(fb_div_m1), 399);
        chk(int'(bwadj_m1) == 49, "R5", "bwadj kept", int'(bwadj_m1), 49);

        // R6 refused codes
        for (int c = 4; c < 8; c++) begin
            run_seq(c, 1'b1);
            chk(t_err == 1, "R6", "error cycle", t_err, 1);
            chk(err_next == 0, "R6", "error one cycle", err_next, 0);
            chk(t_slow < 0 && t_rst < 0 && mode_slow == 0, "R6", "no slow/reset", t_slow, -1);
            chk(int'(fb_div_m1) == 399 && int'(ref_div_m1) == 8 && int'(out_div_m1) == 1,
                "R6", "fields kept", int'(fb_div_m1), 399);
        end

        // R9 start while busy ignored
        poke_busy = 1;
        run_seq(2, 1'b1);
        poke_busy = 0;
        chk(t_rel == 3 + SETTLE, "R9", "release unshifted", t_rel, 3 + SETTLE);
        chk(int'(fb_div_m1) == 499 && t_done > 0, "R9", "fb after poke", int'(fb_div_m1), 499);
        repeat (3) @(negedge clk);
        chk(mode_slow == 0 && pll_rst == 0, "R9", "no second run", {mode_slow, pll_rst}, 0);

        // R8 lock timeout
        force_nolock = 1;
        run_seq(3, 1'b1);
        chk(t_err == 3 + SETTLE + TMO, "R8", "timeout cycle", t_err, 3 + SETTLE + TMO);
        chk(t_done < 0, "R8", "no done", t_done, -1);
        chk(mode_slow == 1, "R8", "still slow", int'(mode_slow), 1);
        chk(pll_rst == 0, "R8", "reset released", int'(pll_rst), 0);
        force_nolock = 0;

        // recovery after timeout
        run_seq(0, 1'b1);
        chk(t_done > 0 && mode_slow == 0, "R7", "recovery done", t_done, 1);
        chk(int'(fb_div_m1) == 24, "R2", "recovery fb", int'(fb_div_m1), 24);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule